// File: doc/BRIEF.md
# 64-bit Word-Operation Execute Unit

This block decodes and executes the 32-bit "word" integer operations of a 64-bit RISC-V core. These are the add, subtract and shift forms that work on the low half of the operands. On each strobe it takes one instruction word and two 64-bit operand values. It computes a 32-bit result, widens it to 64 bits by copying bit 31, and registers it together with the destination index. It pulses a one-cycle valid flag, or an illegal flag when the encoding is not a legal word operation.

The pipeline feeds it operands that have already been read and forwarded. It returns its result one clock after the strobe. The registered result stays unchanged until the next legal operation, so a later stage may sample it at any time.

Top module: `wordop_exec`

## Requirements
- R1: A synchronous reset clears the result, the destination index, the valid flag and the illegal flag to zero.
- R2: An operation presented with `in_valid` high appears on the outputs one clock later, with a one-cycle pulse on `out_valid` or on `out_illegal`. While `in_valid` is low, both flags are low and `out_result` keeps its value.
- R3: Opcode bits 6:0 = 0011011 with funct3 (bits 14:12) = 000 adds the sign-extended 12-bit immediate in bits 31:20 to `src1`. Any value in bits 31:25 is accepted. An immediate of zero yields the sign-extension of `src1[31:0]`.
- R4: Opcode 0111011 with funct3 000 adds `src2` to `src1` when bits 31:25 = 0000000, and subtracts `src2` from `src1` when they are 0100000. Overflow is discarded.
- R5: funct3 001 is a left shift with zero fill. The register form (0111011) takes the amount from `src2[4:0]`. The immediate form (0011011) takes it from bits 24:20.
- R6: funct3 101 is a right shift. Bits 31:25 = 0000000 gives a logical shift that fills with zeros from bit 31 of the low word. 0100000 gives an arithmetic shift that fills with copies of bit 31. The shift amount comes from the same source as in R5.
- R7: Every result is bits 31:0 of the word computation with bit 31 copied into bits 63:32. Bits 63:32 of `src1` and `src2`, and `src2[31:5]` for shifts, have no effect.
- R8: An immediate shift (opcode 0011011, funct3 001 or 101) with bit 25 set is reserved and raises `out_illegal`.
- R9: Any other encoding raises `out_illegal` and never `out_valid`. This covers other opcodes, other funct3 values, a bits 31:25 pattern other than 0000000 or 0100000, and 0100000 with a left shift. On an illegal operation `out_result` is left unchanged.
- R10: `out_rd` takes instruction bits 11:7 on every strobe, legal or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: instruction and operands are present |
| insn | input | 32 | Instruction word |
| src1 | input | 64 | First operand value |
| src2 | input | 64 | Second operand value |
| out_valid | output | 1 | One-cycle pulse: legal operation completed |
| out_illegal | output | 1 | One-cycle pulse: encoding rejected |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Sign-extended word result |

## Verification
Every shift kind, in both immediate and register form, is swept over all 32 shift amounts. The operands are 0x7FFFFFFF, 0x80000000, all-ones upper halves and a mixed pattern. This separates zero fill from sign fill and shows that only five amount bits count. Add and subtract are tried on pairs of the same edge values and on random operands. Those pairs expose missing wrap-around, and garbage placed in the upper operand halves exposes any leak into the result. All 128 bits 31:25 patterns are swept across each funct3 of both forms. This separates the legal encodings from the reserved ones and confirms that a rejected operation leaves the result unchanged.

// File: rtl/wordop_exec.sv
module wordop_exec (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] insn,
  input  logic [63:0] src1,
  input  logic [63:0] src2,
  output logic        out_valid,
  output logic        out_illegal,
  output logic [4:0]  out_rd,
  output logic [63:0] out_result
);
  localparam logic [6:0] OPC_IMM = 7'b0011011;
  localparam logic [6:0] OPC_REG = 7'b0111011;
  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  wire       is_imm = insn[6:0] == OPC_IMM;
  wire       is_reg = insn[6:0] == OPC_REG;
  wire [2:0] f3     = insn[14:12];
  wire [6:0] f7     = insn[31:25];
  wire       f7_ok  = (f7 == F7_BASE) || (f7 == F7_ALT);
  wire       alt    = insn[30];

  logic legal;
  always_comb begin
    legal = 1'b0;
    if (is_imm) begin
      case (f3)
        3'b000:  legal = 1'b1;
        3'b001:  legal = f7 == F7_BASE;
        3'b101:  legal = f7_ok;
        default: legal = 1'b0;
      endcase
    end else if (is_reg) begin
      case (f3)
        3'b000, 3'b101: legal = f7_ok;
        3'b001:         legal = f7 == F7_BASE;
        default:        legal = 1'b0;
      endcase
    end
  end

  wire [31:0] a_w   = src1[31:0];
  wire [31:0] b_w   = is_imm ? {{20{insn[31]}}, insn[31:20]} : src2[31:0];
  wire [4:0]  shamt = is_imm ? insn[24:20] : src2[4:0];

  logic [31:0] word;
  always_comb begin
    case (f3)
      3'b000:  word = (alt && is_reg) ? a_w - b_w : a_w + b_w;
      3'b001:  word = a_w << shamt;
      default: word = alt ? 32'($signed(a_w) >>> shamt) : a_w >> shamt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid && legal;
      out_illegal <= in_valid && !legal;
      if (in_valid) out_rd <= insn[11:7];
      if (in_valid && legal) out_result <= {{32{word[31]}}, word};
    end
  end
endmodule

// File: rtl/wordop_exec_chk.sv
module wordop_exec_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] insn,
  input logic        out_valid,
  input logic        out_illegal,
  input logic [4:0]  out_rd,
  input logic [63:0] out_result
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (out_result == 64'd0 && out_rd == 5'd0 && !out_valid && !out_illegal)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && !out_illegal)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_result)); // R2
  AST_SEXT_UPPER: assert property (@(posedge clk) disable iff (rst) out_valid |-> out_result[63:32] == {32{out_result[31]}}); // R7
  AST_RESERVED_SHAMT: assert property (@(posedge clk) disable iff (rst) (in_valid && insn[6:0] == 7'b0011011 && insn[13:12] == 2'b01 && insn[25]) |=> out_illegal); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst) !(out_valid && out_illegal)); // R9
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst) out_illegal |-> $stable(out_result)); // R9
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_rd == $past(insn[11:7])); // R10
endmodule

bind wordop_exec wordop_exec_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
  .out_valid(out_valid), .out_illegal(out_illegal),
  .out_rd(out_rd), .out_result(out_result)
);

// File: tb/wordop_exec_tb.sv
`timescale 1ns/1ps
module wordop_exec_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] src1 = '0, src2 = '0;
  logic        out_valid, out_illegal;
  logic [4:0]  out_rd;
  logic [63:0] out_result;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] exp_res = '0;

  wordop_exec u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src1(src1), .src2(src2), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_rd(out_rd), .out_result(out_result));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] r2,
      input logic [4:0] r1, input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {f7, r2, r1, f3, rd, op};
  endfunction

  function automatic bit ref_legal(input logic [31:0] w);
    logic [6:0] f7 = w[31:25];
    logic [2:0] f3 = w[14:12];
    if (w[6:0] == 7'b0011011) begin
      if (f3 == 3'b000) return 1;
      if (f3 == 3'b001) return f7 == 7'd0;
      if (f3 == 3'b101) return f7 == 7'd0 || f7 == 7'h20;
      return 0;
    end
    if (w[6:0] == 7'b0111011) begin
      if (f3 == 3'b000 || f3 == 3'b101) return f7 == 7'd0 || f7 == 7'h20;
      if (f3 == 3'b001) return f7 == 7'd0;
      return 0;
    end
    return 0;
  endfunction

  function automatic logic [63:0] ref_val(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] x = a[31:0];
    logic [31:0] y;
    logic [31:0] r;
    int sh;
    bit imm = w[6:0] == 7'b0011011;
    y  = imm ? {{20{w[31]}}, w[31:20]} : b[31:0];
    sh = imm ? int'(w[24:20]) : int'(b[4:0]);
    case (w[14:12])
      3'b000: r = (!imm && w[31:25] == 7'h20) ? x + ~y + 32'd1 : x + y;
      3'b001: r = x * (32'd1 << sh);
      default: begin
        r = x / (32'd1 << sh);
        if (w[31:25] == 7'h20 && x[31]) r = r | ~(32'hFFFF_FFFF >> sh);
      end
    endcase
    return {{32{r[31]}}, r};
  endfunction

  task automatic run(input string req, input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
    bit lg = ref_legal(w);
    logic [63:0] held;
    @(negedge clk);
    insn = w; src1 = a; src2 = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; insn = $urandom; src1 = {$urandom, $urandom}; src2 = {$urandom, $urandom};
    if (lg) exp_res = ref_val(w, a, b);
    chk(req, out_result, exp_res);
    chk(req, {62'd0, out_valid, out_illegal}, {62'd0, lg, !lg});
    chk("R10", {59'd0, out_rd}, {59'd0, w[11:7]});
    held = out_result;
    @(negedge clk);
    chk("R2", {63'd0, out_valid | out_illegal}, 64'd0);
    chk("R2", out_result, held);
  endtask

  logic [63:0] edges [5] = '{64'h0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_8000_0000,
                             64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_0F0F_9ABC_DEF0};

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", out_result, 64'd0);
    chk("R1", {59'd0, out_rd, out_valid, out_illegal}, 64'd0);
    rst = 1'b0;

    // R5 R6 R7: all shift amounts, both forms, upper bits of src2 scrambled
    foreach (edges[i]) begin
      for (int sh = 0; sh < 32; sh++) begin
        logic [63:0] bb = {$urandom, 27'($urandom), 5'(sh)};
        run("R5", mk(7'h00, 5'(sh), 5'd1, 3'b001, 5'(sh), 7'b0011011), edges[i], bb);
        run("R6", mk(7'h00, 5'(sh), 5'd1, 3'b101, 5'd3, 7'b0011011), edges[i], bb);
        run("R6", mk(7'h20, 5'(sh), 5'd1, 3'b101, 5'd4, 7'b0011011), edges[i], bb);
        run("R5", mk(7'h00, 5'd2, 5'd1, 3'b001, 5'd5, 7'b0111011), edges[i], bb);
        run("R6", mk(7'h00, 5'd2, 5'd1, 3'b101, 5'd6, 7'b0111011), edges[i], bb);
        run("R6", mk(7'h20, 5'd2, 5'd1, 3'b101, 5'd7, 7'b0111011), edges[i], bb);
      end
    end

    // R4 R7: register add/sub on edge pairs
    foreach (edges[i]) foreach (edges[j]) begin
      run("R4", mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd8, 7'b0111011), edges[i], edges[j]);
      run("R4", mk(7'h20, 5'd2, 5'd1, 3'b000, 5'd9, 7'b0111011), edges[i], edges[j]);
    end

    // R3: immediate add, including zero immediate (sign-extend only)
    foreach (edges[i]) begin
      run("R3", {12'h000, 5'd1, 3'b000, 5'd10, 7'b0011011}, edges[i], 64'h0);
      run("R3", {12'h001, 5'd1, 3'b000, 5'd11, 7'b0011011}, edges[i], 64'h0);
      run("R3", {12'hFFF, 5'd1, 3'b000, 5'd12, 7'b0011011}, edges[i], 64'h0);
      run("R3", {12'h7FF, 5'd1, 3'b000, 5'd13, 7'b0011011}, edges[i], 64'h0);
      run("R3", {12'h800, 5'd1, 3'b000, 5'd14, 7'b0011011}, edges[i], 64'h0);
    end

    // R3 R4 R7: random operands
    for (int k = 0; k < 300; k++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      run("R3", {12'($urandom), 5'd1, 3'b000, 5'($urandom), 7'b0011011}, a, b);
      run("R4", mk((k % 2) ? 7'h20 : 7'h00, 5'd2, 5'd1, 3'b000, 5'($urandom), 7'b0111011), a, b);
    end

    // R8 R9: sweep every bits 31:25 pattern over each funct3 and form
    for (int f = 0; f < 128; f++) begin
      for (int g = 0; g < 8; g++) begin
        logic [63:0] a = {$urandom, $urandom};
        run("R9", mk(7'(f), 5'($urandom), 5'd1, 3'(g), 5'($urandom), 7'b0111011), a, {$urandom, $urandom});
        run((g == 1 || g == 5) ? "R8" : "R9",
            mk(7'(f), 5'($urandom), 5'd1, 3'(g), 5'($urandom), 7'b0011011), a, {$urandom, $urandom});
      end
    end

    // R9: foreign opcodes
    run("R9", mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd15, 7'b0110011), 64'h5, 64'h6);
    run("R9", mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd16, 7'b0010011), 64'h5, 64'h6);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule